// File: doc/BRIEF.md
# Credit-Based Completion Interrupt Controller

This block decides when one descriptor ring raises its completion interrupt. A strobe from the ring's completion logic adds one credit for every finished descriptor; software hands credits back by writing a count, which is taken off the total. The block emits a single-cycle interrupt request and keeps its own self-mask flag. This flag has no link to any mask bit in the interrupt message table. The credit total, the self-mask state and a sticky error flag can all be read back.

The first completion seen while unmasked raises one request and sets the self-mask. Later completions only add credits. A credit return that clears the total drops the mask without raising a request. A credit return that leaves work outstanding keeps the mask set and raises exactly one new request, so the handler runs again. The credit return port is a valid/ready stream. Ready is held high at all times, so every beat offered is taken in the cycle it is presented and the port never applies back-pressure.

Top module: `credit_irq_ctrl`

## Requirements
- R1: A completion strobe with no credit return increments `credits` by one on the next clock edge. The count holds at its all-ones maximum rather than wrapping.
- R2: An accepted credit return subtracts `ret_count` from `credits`.
- R3: When a completion and a credit return arrive in the same cycle, the next count is old count + 1 - `ret_count`. The firing decision is made on that result.
- R4: A completion with no return while `masked` is 0 gives `irq` = 1 for exactly one cycle, starting the cycle after the strobe. `masked` becomes 1 in that same cycle.
- R5: A completion with no return while `masked` is 1 does not raise `irq`, and `masked` stays 1.
- R6: A credit return whose result is zero clears `masked` and does not raise `irq`.
- R7: A credit return whose result is above zero sets `masked` to 1 and raises `irq` for exactly one cycle.
- R8: A return larger than the available count sets `credits` to 0 and sets `ovf_err`. `ovf_err` stays 1 until a reset, and the return is otherwise treated as in R6.
- R9: Asynchronous reset (`rst_n` = 0) and synchronous `ring_reset` both give `credits` = 0, `masked` = 0, `ovf_err` = 0 and `irq` = 0. `ring_reset` takes priority over same-cycle stimulus.
- R10: `ret_ready` is 1 in every cycle out of reset, so no return beat is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_reset | input | 1 | Synchronous ring reset |
| cmpl_strobe | input | 1 | One descriptor completed this cycle |
| ret_valid | input | 1 | Credit return beat offered |
| ret_ready | output | 1 | Credit return beat accepted (always high) |
| ret_count | input | CNT_W | Number of credits returned |
| irq | output | 1 | One-cycle interrupt request |
| credits | output | CNT_W | Outstanding credit count |
| masked | output | 1 | Self-mask state |
| ovf_err | output | 1 | Sticky over-return error |

## Verification
Every result is registered. `credits`, `masked`, `ovf_err` and `irq` all reflect a stimulus one clock edge after it is applied, and `irq` falls again one edge later. The bench changes inputs on the falling edge and compares all four outputs on the following falling edge against a count model kept in the bench. In that way each compare sits exactly one edge after the stimulus it judges. Sweeps cover every pairing of a starting credit count from 0 to 4, a returned amount from 0 to 6 and a present or absent same-cycle completion.

// File: rtl/credit_irq_pkg.sv
package credit_irq_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ARM    = 2'd1,
    EV_RELOAD = 2'd2,
    EV_SILENT = 2'd3
  } fire_ev_t;
endpackage

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec_valid,
  input  logic [CNT_W-1:0] dec_amt,
  output logic [CNT_W-1:0] count,
  output logic             nxt_zero,
  output logic             ovf
);
  localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   sum_sat;
  logic [CNT_W-1:0] nxt;
  logic             under;

  always_comb begin
    sum     = {1'b0, count} + {{CNT_W{1'b0}}, inc};
    sum_sat = (sum > MAXV) ? MAXV : sum;
    under   = 1'b0;
    nxt     = sum_sat[CNT_W-1:0];
    if (dec_valid) begin
      if ({1'b0, dec_amt} > sum_sat) begin
        nxt   = '0;
        under = 1'b1;
      end else begin
        nxt = sum_sat[CNT_W-1:0] - dec_amt;
      end
    end
  end

  assign nxt_zero = (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= nxt;
      ovf   <= ovf | under;
    end
  end
endmodule

// File: rtl/automask_fsm.sv
module automask_fsm
  import credit_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic ret_take,
  input  logic nxt_zero,
  output logic masked,
  output logic irq
);
  fire_ev_t ev;

  always_comb begin
    ev = EV_NONE;
    if (ret_take)
      ev = nxt_zero ? EV_SILENT : EV_RELOAD;
    else if (inc && !masked)
      ev = EV_ARM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked <= 1'b0;
      irq    <= 1'b0;
    end else if (clr) begin
      masked <= 1'b0;
      irq    <= 1'b0;
    end else begin
      unique case (ev)
        EV_ARM, EV_RELOAD: begin
          masked <= 1'b1;
          irq    <= 1'b1;
        end
        EV_SILENT: begin
          masked <= 1'b0;
          irq    <= 1'b0;
        end
        default: irq <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/credit_irq_ctrl.sv
module credit_irq_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_reset,
  input  logic             cmpl_strobe,
  input  logic             ret_valid,
  output logic             ret_ready,
  input  logic [CNT_W-1:0] ret_count,
  output logic             irq,
  output logic [CNT_W-1:0] credits,
  output logic             masked,
  output logic             ovf_err
);
  logic ret_take;
  logic nxt_zero;

  assign ret_ready = 1'b1;
  assign ret_take  = ret_valid & ret_ready;

  credit_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ring_reset),
    .inc      (cmpl_strobe),
    .dec_valid(ret_take),
    .dec_amt  (ret_count),
    .count    (credits),
    .nxt_zero (nxt_zero),
    .ovf      (ovf_err)
  );

  automask_fsm fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ring_reset),
    .inc     (cmpl_strobe),
    .ret_take(ret_take),
    .nxt_zero(nxt_zero),
    .masked  (masked),
    .irq     (irq)
  );
endmodule

// File: rtl/credit_irq_chk.sv
module credit_irq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ring_reset,
  input logic             cmpl_strobe,
  input logic             ret_valid,
  input logic             ret_ready,
  input logic [CNT_W-1:0] ret_count,
  input logic             irq,
  input logic [CNT_W-1:0] credits,
  input logic             masked,
  input logic             ovf_err
);
  // R1
  inc_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_strobe && !ret_valid && !ring_reset && credits != {CNT_W{1'b1}})
      |=> credits == $past(credits) + 1'b1);
  // R4
  arm_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_strobe && !masked && !ret_valid && !ring_reset) |=> (irq && masked));
  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_strobe && masked && !ret_valid && !ring_reset) |=> (!irq && masked));
  // R7
  ret_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ring_reset) |=> (irq == (credits != '0)));
  // R6
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> masked);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !ring_reset) |=> ovf_err);
  // R9
  ring_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_reset |=> (credits == '0 && !masked && !ovf_err && !irq));
  // R10
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n) ret_ready);
endmodule

bind credit_irq_ctrl credit_irq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ring_reset (ring_reset),
  .cmpl_strobe(cmpl_strobe),
  .ret_valid  (ret_valid),
  .ret_ready  (ret_ready),
  .ret_count  (ret_count),
  .irq        (irq),
  .credits    (credits),
  .masked     (masked),
  .ovf_err    (ovf_err)
);

// File: tb/credit_irq_ctrl_tb_top.sv
module credit_irq_ctrl_tb_top;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ring_reset = 1'b0;
  logic          cmpl_strobe = 1'b0;
  logic          ret_valid = 1'b0;
  logic          ret_ready;
  logic [CW-1:0] ret_count = '0;
  logic          irq;
  logic [CW-1:0] credits;
  logic          masked;
  logic          ovf_err;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  longint m_cr = 0;
  bit     m_mask = 0;
  bit     m_ovf = 0;
  bit     m_irq = 0;

  always #10 clk = ~clk;

  credit_irq_ctrl #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ring_reset(ring_reset),
    .cmpl_strobe(cmpl_strobe), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_count(ret_count), .irq(irq), .credits(credits),
    .masked(masked), .ovf_err(ovf_err)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "credits", longint'(credits), m_cr);
    chk(tag, "masked", longint'(masked), longint'(m_mask));
    chk(tag, "ovf_err", longint'(ovf_err), longint'(m_ovf));
    chk(tag, "irq", longint'(irq), longint'(m_irq));
    chk("R10", "ret_ready", longint'(ret_ready), 1);
  endtask

  // Apply one cycle of stimulus at a falling edge, update the model, compare one edge later.
  task automatic step(input string tag, input bit c, input bit rv, input longint rc, input bit rr);
    longint s;
    ring_reset  = rr;
    cmpl_strobe = c;
    ret_valid   = rv;
    ret_count   = CW'(rc);
    if (rr) begin
      m_cr = 0; m_mask = 0; m_ovf = 0; m_irq = 0;
    end else begin
      s = m_cr + longint'(c);
      m_irq = 0;
      if (rv) begin
        if (rc > s) begin m_cr = 0; m_ovf = 1; end
        else m_cr = s - rc;
        m_mask = (m_cr != 0);
        m_irq  = (m_cr != 0);
      end else begin
        m_cr = s;
        if (c && !m_mask) begin m_mask = 1; m_irq = 1; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    ring_reset = 0; cmpl_strobe = 0; ret_valid = 0; ret_count = '0;
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R9");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9");

    // Basic arm, masked completions, idle decay of the pulse
    step("R4", 1, 0, 0, 0);
    step("R5", 1, 0, 0, 0);
    step("R5", 1, 0, 0, 0);
    step("R1", 0, 0, 0, 0);
    step("R7", 0, 1, 1, 0);
    step("R6", 0, 1, 2, 0);
    step("R4", 1, 0, 0, 0);
    step("R9", 1, 1, 3, 1);

    // Sweep: start count, returned amount, same-cycle completion
    for (int st = 0; st <= 4; st++) begin
      for (int ra = 0; ra <= 6; ra++) begin
        for (int cm = 0; cm <= 1; cm++) begin
          step("R9", 0, 0, 0, 1);
          for (int k = 0; k < st; k++)
            step((k == 0) ? "R4" : "R5", 1, 0, 0, 0);
          if (ra > st + cm)       step("R8", cm[0], 1, ra, 0);
          else if (cm == 1)       step("R3", 1, 1, ra, 0);
          else if (ra == st)      step("R6", 0, 1, ra, 0);
          else                    step("R2", 0, 1, ra, 0);
          step("R8", 0, 0, 0, 0);
        end
      end
    end

    // Sticky error survives later activity, cleared by ring reset
    step("R8", 0, 1, 5, 0);
    step("R8", 1, 0, 0, 0);
    step("R8", 0, 1, 1, 0);
    step("R9", 0, 0, 0, 1);

    // Asynchronous reset mid-run
    step("R4", 1, 0, 0, 0);
    rst_n = 1'b0;
    m_cr = 0; m_mask = 0; m_ovf = 0; m_irq = 0;
    @(negedge clk);
    compare("R9");
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule